// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the sixteen general-purpose registers of a processor core together with the private copies that become visible when the core enters an exception mode. The core presents its current 5-bit mode value on `mode_i`. It also presents two read addresses and one write address, all architectural register numbers. A decoder turns the mode into a bank selection, and a small index map per port translates each architectural number into a slot of one flat physical array. The array holds the common registers and every banked copy side by side. No value is ever copied when the mode changes: the map points somewhere else.

Fast-interrupt mode owns private copies of registers 8 through 14. The interrupt, supervisor, abort and undefined modes each own private copies of registers 13 and 14 only. Each of those five modes also owns one saved-status word. The core writes that word and reads it back through a dedicated port, and the port always addresses the word belonging to the mode currently on `mode_i`. Any mode encoding outside the five exception modes sees only the common registers and has no saved-status word.

Reads are combinational from the current mode and address. Writes take effect at the rising clock edge, using the mode present at that edge.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every physical register is cleared to zero at that edge. This covers the common registers, every banked copy and all five saved-status words.
- R2: Registers 0 to 7 and register 15 are one shared set that is seen identically in every mode encoding.
- R3: In mode 5'h11, registers 8 to 14 select that mode's private copies. These copies are separate from the common set and from every other mode's copies.
- R4: In modes 5'h12, 5'h13, 5'h17 and 5'h1B, registers 13 and 14 select a private pair owned by that one mode. Registers 8 to 12 in these modes are the common ones.
- R5: Any mode encoding other than the five above, for example 5'h10, 5'h1F or 5'h00, reaches only the common registers.
- R6: The two read ports return, without a clock, the value of the register named by their own address under the present mode. They do so independently of each other, and a value written at an edge is visible right after that edge.
- R7: A write is steered by the mode present at the clock edge. If the mode changes in the same cycle as a write, the write lands in the new mode's copy, and the old mode's copy keeps its value.
- R8: Each of the five exception modes has its own saved-status word. A saved-status write updates only the current mode's word, and the saved-status read returns the current mode's word.
- R9: In a non-exception mode, a saved-status write changes no stored word, and the saved-status read returns zero.
- R10: With `wr_en_i` low, no register changes, whatever the write address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current processor mode value |
| rd_a_addr_i | input | 4 | Read port A architectural register number |
| rd_a_data_o | output | DW | Read port A data |
| rd_b_addr_i | input | 4 | Read port B architectural register number |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 4 | Write architectural register number |
| wr_data_i | input | DW | Write data |
| sst_wr_en_i | input | 1 | Saved-status write enable for the current mode |
| sst_wr_data_i | input | DW | Saved-status write data |
| sst_rd_data_o | output | DW | Saved-status word of the current mode, zero outside exception modes |

## Verification
The assertions take `mode_i`, the addresses and both write enables to be known, non-X values at every rising edge once reset is released. They also take the bank decoder to see the same mode as the write path within a cycle. The stimulus respects this by changing inputs only just after a falling edge and by holding every input at a defined value from time zero, including the idle cycles between operations. Mode values are drawn from a fixed table that covers each exception code and three codes outside that set. They are applied in a scrambled order, so every bank is entered from several different predecessors.

// File: rtl/rfb_pkg.sv
// Shared constants and types for the mode-banked register file.
// Assumes a 16-entry architectural file and the five fixed exception mode codes.
package rfb_pkg;

    localparam int          NREG       = 16;
    localparam int          AW         = $clog2(NREG);
    localparam int          MODE_W     = 5;

    localparam logic [4:0]  MODE_FIQ   = 5'h11;
    localparam logic [4:0]  MODE_IRQ   = 5'h12;
    localparam logic [4:0]  MODE_SVC   = 5'h13;
    localparam logic [4:0]  MODE_ABT   = 5'h17;
    localparam logic [4:0]  MODE_UND   = 5'h1B;

    // Architectural ranges that are banked.
    localparam int          FIQ_LO     = 8;
    localparam int          SMALL_LO   = 13;
    localparam int          BANK_HI    = 14;
    localparam int          FIQ_CNT    = BANK_HI - FIQ_LO + 1;
    localparam int          SMALL_CNT  = BANK_HI - SMALL_LO + 1;
    localparam int          NSMALL     = 4;
    localparam int          NEXC       = NSMALL + 1;

    // Flat physical layout: common | fast-interrupt copies | small pairs.
    localparam int          FIQ_BASE   = NREG;
    localparam int          SMALL_BASE = FIQ_BASE + FIQ_CNT;
    localparam int          NPHYS      = SMALL_BASE + SMALL_CNT * NSMALL;
    localparam int          PHYS_W     = $clog2(NPHYS);
    localparam int          SLOT_W     = $clog2(NEXC);

    // Bank selection; the small-pair banks are consecutive from BK_IRQ.
    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

endpackage

// File: rtl/rfb_mode_decode.sv
// Turns the raw mode value into a bank selection.
// Assumes any code outside the five exception codes selects no bank.
module rfb_mode_decode
    import rfb_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);

    // Map each exception code to its bank, everything else to the common set.
    always_comb begin
        case (mode_i)
            MODE_FIQ: bank_o = BK_FIQ;
            MODE_IRQ: bank_o = BK_IRQ;
            MODE_SVC: bank_o = BK_SVC;
            MODE_ABT: bank_o = BK_ABT;
            MODE_UND: bank_o = BK_UND;
            default:  bank_o = BK_NONE;
        endcase
    end

endmodule

// File: rtl/rfb_index_map.sv
// Translates an architectural register number into a physical slot
// for the given bank. Purely combinational; one instance per port.
module rfb_index_map
    import rfb_pkg::*;
(
    input  logic [AW-1:0]     arch_i,
    input  bank_e             bank_i,
    output logic [PHYS_W-1:0] phys_o
);

    // Pick the common slot unless the bank owns this register.
    always_comb begin
        int a;
        int b;
        a      = int'(arch_i);
        b      = int'(bank_i) - int'(BK_IRQ);
        phys_o = PHYS_W'(a);
        if (bank_i == BK_FIQ && a >= FIQ_LO && a <= BANK_HI) begin
            phys_o = PHYS_W'(FIQ_BASE + a - FIQ_LO);
        end else if (bank_i != BK_NONE && bank_i != BK_FIQ &&
                     a >= SMALL_LO && a <= BANK_HI) begin
            phys_o = PHYS_W'(SMALL_BASE + b * SMALL_CNT + a - SMALL_LO);
        end
    end

endmodule

// File: rtl/rfb_store.sv
// Flat physical register array: one write port, two combinational reads.
// Assumes write and read indices are always below NPHYS.
module rfb_store
    import rfb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PHYS_W-1:0] widx_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [PHYS_W-1:0] ridx_a_i,
    input  logic [PHYS_W-1:0] ridx_b_i,
    output logic [DW-1:0]     rdata_a_o,
    output logic [DW-1:0]     rdata_b_o
);

    logic [DW-1:0] mem [NPHYS];

    // Clear everything in reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[widx_i] <= wdata_i;
        end
    end

    // Unclocked read ports.
    assign rdata_a_o = mem[ridx_a_i];
    assign rdata_b_o = mem[ridx_b_i];

    // Checker-only reduction: is any physical slot nonzero?
    logic any_set;
    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < NPHYS; i++) any_set = any_set | (|mem[i]);
    end

    // R1: the cycle after reset is released, every slot is still zero.
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !any_set);

    // R6: a written value is present in its slot after the edge.
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem[$past(widx_i)] == $past(wdata_i));

    // R10: without a write the array holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> mem[$past(widx_i)] == $past(mem[widx_i]));

endmodule

// File: rtl/rfb_saved_status.sv
// One saved-status word per exception mode, addressed by the current bank.
// Assumes BK_NONE carries no word; reads there return zero.
module rfb_saved_status
    import rfb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bank_e         bank_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);

    logic [NEXC-1:0][DW-1:0] word_q;
    logic [SLOT_W-1:0]       slot;
    logic                    has_slot;

    // Bank index minus one gives the slot; BK_NONE has none.
    assign has_slot = (bank_i != BK_NONE);
    assign slot     = SLOT_W'(int'(bank_i) - 1);

    // Clear in reset, else write the current mode's word.
    always_ff @(posedge clk) begin
        if (!rst_n)                word_q       <= '0;
        else if (we_i && has_slot) word_q[slot] <= wdata_i;
    end

    // Present the current mode's word, or zero outside exception modes.
    assign rdata_o = has_slot ? word_q[slot] : '0;

    // R8: a write in an exception mode lands in that mode's word.
    a_r8_own_word: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && has_slot) |=> word_q[$past(slot)] == $past(wdata_i));

    // R9: a write outside exception modes leaves all words unchanged.
    a_r9_no_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !has_slot) |=> $stable(word_q));

endmodule

// File: rtl/banked_regfile.sv
// Mode-banked register file top: decodes the mode once, maps three ports
// (two reads, one write) to physical slots and drives the shared array
// and the saved-status words. Assumes all inputs are stable at each edge.
module banked_regfile
    import rfb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    mode_i,
    input  logic [3:0]    rd_a_addr_i,
    output logic [DW-1:0] rd_a_data_o,
    input  logic [3:0]    rd_b_addr_i,
    output logic [DW-1:0] rd_b_data_o,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          sst_wr_en_i,
    input  logic [DW-1:0] sst_wr_data_i,
    output logic [DW-1:0] sst_rd_data_o
);

    localparam int NPORT = 3;   // read A, read B, write

    bank_e             bank;
    logic [AW-1:0]     port_arch [NPORT];
    logic [PHYS_W-1:0] port_phys [NPORT];

    rfb_mode_decode u_dec (
        .mode_i (mode_i),
        .bank_o (bank)
    );

    assign port_arch[0] = rd_a_addr_i;
    assign port_arch[1] = rd_b_addr_i;
    assign port_arch[2] = wr_addr_i;

    // One address map per port, all fed by the same bank selection.
    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rfb_index_map u_map (
            .arch_i (port_arch[g]),
            .bank_i (bank),
            .phys_o (port_phys[g])
        );
    end

    rfb_store #(.DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i),
        .widx_i    (port_phys[2]),
        .wdata_i   (wr_data_i),
        .ridx_a_i  (port_phys[0]),
        .ridx_b_i  (port_phys[1]),
        .rdata_a_o (rd_a_data_o),
        .rdata_b_o (rd_b_data_o)
    );

    rfb_saved_status #(.DW(DW)) u_sst (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (bank),
        .we_i    (sst_wr_en_i),
        .wdata_i (sst_wr_data_i),
        .rdata_o (sst_rd_data_o)
    );

    // R2: shared registers map to themselves in any mode.
    a_r2_shared_index: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(wr_addr_i) < FIQ_LO || int'(wr_addr_i) == NREG - 1)
        |-> int'(port_phys[2]) == int'(wr_addr_i));

    // R3: fast-interrupt mode sends R8..R14 into its private region.
    a_r3_fiq_private: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FIQ && int'(wr_addr_i) >= FIQ_LO &&
         int'(wr_addr_i) <= BANK_HI)
        |-> (int'(port_phys[2]) >= FIQ_BASE && int'(port_phys[2]) < SMALL_BASE));

    // R4: small-bank modes keep R8..R12 in the common set.
    a_r4_small_common: assert property (@(posedge clk) disable iff (!rst_n)
        (bank != BK_NONE && bank != BK_FIQ && int'(rd_a_addr_i) >= FIQ_LO &&
         int'(rd_a_addr_i) < SMALL_LO)
        |-> int'(port_phys[0]) == int'(rd_a_addr_i));

    // R5: non-exception modes never leave the common set.
    a_r5_plain_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BK_NONE) |-> int'(port_phys[1]) < NREG);

endmodule

// File: tb/banked_regfile_tb.sv
// Self-checking bench: a table of modes written in a scrambled order,
// read back in another order, then directed reset and corner tests.
module banked_regfile_tb;

    localparam int DW = 32;
    localparam int NM = 8;

    localparam logic [4:0] MODES [NM] = '{5'h10, 5'h11, 5'h12, 5'h13,
                                          5'h17, 5'h1B, 5'h1F, 5'h00};
    localparam int WR_ORD [NM] = '{3, 0, 6, 1, 7, 4, 2, 5};
    localparam int RD_ORD [NM] = '{5, 2, 7, 0, 4, 1, 6, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode = 5'h10;
    logic [3:0]    ra = '0, rb = '0, wa = '0;
    logic          we = 1'b0, swe = 1'b0;
    logic [DW-1:0] wd = '0, swd = '0;
    logic [DW-1:0] rda, rdb, srd;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    banked_regfile #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rd_a_addr_i(ra), .rd_a_data_o(rda),
        .rd_b_addr_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .sst_wr_en_i(swe), .sst_wr_data_i(swd), .sst_rd_data_o(srd)
    );

    // Owner of register r in mode m, from R2..R5: 0 common, else owner code.
    function automatic int owner(logic [4:0] m, int r);
        if (m == 5'h11 && r >= 8 && r <= 14) return 32'h11;
        if ((m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B) &&
            r >= 13 && r <= 14) return int'(m);
        return 0;
    endfunction

    function automatic logic [DW-1:0] val(int mi, int r);
        return {4'hA, 4'(mi), 8'(r), 16'(16'h1234 ^ 16'(mi * 37 + r))};
    endfunction

    // Last value written from the table that reaches register r in mode m.
    function automatic logic [DW-1:0] table_exp(logic [4:0] m, int r);
        for (int p = NM - 1; p >= 0; p--) begin
            if (owner(MODES[WR_ORD[p]], r) == owner(m, r)) return val(WR_ORD[p], r);
        end
        return '0;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register through the normal port; ends just after a falling edge.
    task automatic wr(logic [4:0] m, int r, logic [DW-1:0] d);
        mode = m; wa = 4'(r); wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Set up a read on both ports and let the combinational path settle.
    task automatic rd(logic [4:0] m, int a, int b);
        mode = m; ra = 4'(a); rb = 4'(b);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: after reset, banked and common registers and saved words are zero.
        for (int r = 0; r < 16; r++) begin
            rd(5'h11, r, r); check("R1 fiq view", rda, '0);
            rd(5'h12, r, r); check("R1 irq view", rdb, '0);
        end
        rd(5'h13, 0, 0); check("R1 saved status", srd, '0);

        // Table walk: write every register in every mode, scrambled order.
        for (int p = 0; p < NM; p++)
            for (int r = 0; r < 16; r++)
                wr(MODES[WR_ORD[p]], r, val(WR_ORD[p], r));

        // Read back in a different mode order; R2..R6 per register class.
        for (int p = 0; p < NM; p++) begin
            for (int r = 0; r < 16; r++) begin
                logic [4:0] m;
                int rb2;
                m = MODES[RD_ORD[p]];
                rb2 = r ^ 5;
                rd(m, r, rb2);
                if (r < 8 || r == 15)    check("R2 shared reg port A", rda, table_exp(m, r));
                else if (m == 5'h11)     check("R3 fiq bank port A", rda, table_exp(m, r));
                else if (owner(m, r) != 0) check("R4 small bank port A", rda, table_exp(m, r));
                else                     check("R5 common reg port A", rda, table_exp(m, r));
                check("R6 port B independent", rdb, table_exp(m, rb2));
            end
        end

        // R7: mode change and write in the same cycle reach the new mode.
        rd(5'h10, 0, 0);
        @(negedge clk);
        wr(5'h13, 13, 32'hC0FFEE13);
        rd(5'h13, 13, 14);
        check("R7 new mode copy", rda, 32'hC0FFEE13);
        check("R7 neighbour untouched", rdb, table_exp(5'h13, 14));
        rd(5'h10, 13, 13);
        check("R7 old mode copy kept", rda, table_exp(5'h10, 13));

        // R10: disabled write changes nothing.
        mode = 5'h11; wa = 4'd9; wd = 32'hDEADBEEF; we = 1'b0;
        @(negedge clk);
        rd(5'h11, 9, 9);
        check("R10 no write when disabled", rda, table_exp(5'h11, 9));

        // R8: one saved-status word per exception mode.
        for (int k = 1; k <= 5; k++) begin
            mode = MODES[k]; swd = 32'h5EED0000 + 32'(k); swe = 1'b1;
            @(negedge clk);
            swe = 1'b0;
        end
        for (int k = 5; k >= 1; k--) begin
            rd(MODES[k], 0, 0);
            check("R8 saved status per mode", srd, 32'h5EED0000 + 32'(k));
        end

        // R9: saved-status write outside exception modes has no effect.
        mode = 5'h1F; swd = 32'hBAD0BAD0; swe = 1'b1;
        @(negedge clk);
        swe = 1'b0;
        rd(5'h1F, 0, 0); check("R9 read zero in plain mode", srd, '0);
        rd(5'h00, 0, 0); check("R9 read zero in mode 0", srd, '0);
        for (int k = 1; k <= 5; k++) begin
            rd(MODES[k], 0, 0);
            check("R9 words unchanged", srd, 32'h5EED0000 + 32'(k));
        end

        // R1: a second reset clears banked copies and saved words.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'h1B, 14, 3);  check("R1 und copy cleared", rda, '0);
        check("R1 common cleared", rdb, '0);
        rd(5'h11, 8, 12);  check("R1 fiq copy cleared", rda, '0);
        check("R1 fiq R12 cleared", rdb, '0);
        rd(5'h12, 0, 0);   check("R1 saved word cleared", srd, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule